// File: doc/BRIEF.md
# Multi-Read-Port Register File

This block is the general-purpose register file of a small RISC core. It stores 16 words of 16 bits and offers one write port and five read ports. By convention, ports 0 and 1 feed the ALU operands. Ports 2 to 4 serve branch-condition evaluation and program-counter loading. A bank of flip-flops with five wide 16:1 selectors would be costly. The block instead builds its storage from identical memory banks, each with one write port, and lets a parameter pick one of two ways to get five reads out of them.

In replicated mode there is one bank per read port. Every bank sees the same write, and each bank is read at its own port's address. One clock cycle is one core cycle. A read of the address being written in the same cycle returns the old word, unless the forwarding parameter is set; then the incoming write data is bypassed to that port.

In time-multiplexed mode a single bank runs on a clock that is NUM_RD+1 times the core clock. That clock is the block's `clk`, and `cycle_start` marks the first fast cycle of each core cycle. A sequencer gives each fast cycle one access slot, because the bank cannot read and write in the same slot. It has two states:
- SEQ_READ with an index 0..NUM_RD-1. Each slot reads the port whose number equals the index. After the last index the sequencer moves to SEQ_WRITE.
- SEQ_WRITE. This slot performs the write, if one is requested, and then returns to SEQ_READ with index 0.

Reset forces SEQ_READ with index 0. The read results are gathered into holding registers and published together at the end of the write slot.

Top module: `regfile_mp`

## Requirements
- R1: A word written at an address is returned unchanged by any read port that later reads that address (16 addresses, 16-bit words, five read ports; read port k takes its address from rd_addr bits 4k+3..4k and drives rd_data bits 16k+15..16k).
- R2: In replicated mode each of the five ports reads its own address in every clock cycle. The result appears after the next rising edge, and back-to-back cycles each return their own results.
- R3: In replicated mode with forwarding off, a port that reads the address being written in the same cycle returns the word held before the write.
- R4: In replicated mode with forwarding on, a port that reads the address being written in the same cycle returns the new write data.
- R5: In time-multiplexed mode a core cycle lasts NUM_RD+1 = 6 clock cycles, and cycle_start is high only in the first of them (slot 0). The slot order is reads of ports 0 to 4, then the write slot.
- R6: In time-multiplexed mode every read in a core cycle returns the contents from before that cycle's write, even when it reads the written address. The new word is visible from the following core cycle.
- R7: In time-multiplexed mode rd_data changes only at the clock edge that ends the write slot, and it stays constant through the whole following core cycle.
- R8: A synchronous reset returns the sequencer to slot 0 (cycle_start high) and clears all read outputs to zero. The stored register contents survive the reset.
- R9: With wr_en low, no address is modified, whatever wr_addr and wr_data hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; in time-multiplexed mode the fast clock, NUM_RD+1 times the core clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request for this core cycle |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 20 | Five packed read addresses, port k at bits 4k+3..4k |
| rd_data | output | 80 | Five packed read results, port k at bits 16k+15..16k |
| cycle_start | output | 1 | High in slot 0 of each core cycle; held high in replicated mode |

## Verification
The in-line assertions check three properties on every cycle: the sequencer moves from the last read slot to the write slot and then back to slot 0, cycle_start is never high in two consecutive clocks, and the time-multiplexed outputs do not move outside the write slot. With forwarding on they also check that a colliding read returns the last write data. The bench's scenarios are needed to show the data path itself: the slot ordering that gives read-before-write on a collision, the old value on a replicated collision without forwarding, that a write with wr_en low has no effect, and that the contents survive a reset issued in the middle of a core cycle.

// File: rtl/regfile_mp_pkg.sv
package regfile_mp_pkg;

    // How the five read ports are obtained from single-write banks
    typedef enum logic {
        RF_REPLICATED = 1'b0,
        RF_TIMEMUX    = 1'b1
    } rf_mode_e;

    // Access-slot sequencer states (time-multiplexed mode)
    typedef enum logic {
        SEQ_READ  = 1'b0,
        SEQ_WRITE = 1'b1
    } seq_state_e;

endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rf_slot_seq.sv
module rf_slot_seq import regfile_mp_pkg::*; #(
    parameter int NUM_RD = 5,
    localparam int IW    = (NUM_RD > 1) ? $clog2(NUM_RD) : 1
) (
    input  logic          clk,
    input  logic          rst,
    output logic          rd_slot,
    output logic          wr_slot,
    output logic [IW-1:0] rd_sel,
    output logic          cycle_start
);

    localparam logic [IW-1:0] LAST = IW'(NUM_RD - 1);

    seq_state_e    state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_READ;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            SEQ_READ: begin
                if (idx_q == LAST) begin
                    state_d = SEQ_WRITE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            SEQ_WRITE: begin
                state_d = SEQ_READ;
                idx_d   = '0;
            end
            default: ;
        endcase
    end

    always_comb begin
        rd_slot     = 1'b0;
        wr_slot     = 1'b0;
        cycle_start = 1'b0;
        unique case (state_q)
            SEQ_READ: begin
                rd_slot     = 1'b1;
                cycle_start = (idx_q == '0);
            end
            SEQ_WRITE: wr_slot = 1'b1;
            default: ;
        endcase
    end

    assign rd_sel = idx_q;

    // R5
    seq_last_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_READ && idx_q == LAST) |=> (state_q == SEQ_WRITE));

    // R5
    seq_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_WRITE) |=> (state_q == SEQ_READ && idx_q == '0));

endmodule

// File: rtl/regfile_mp.sv
module regfile_mp import regfile_mp_pkg::*; #(
    parameter int       DW     = 16,
    parameter int       DEPTH  = 16,
    parameter int       NUM_RD = 5,
    parameter rf_mode_e MODE   = RF_TIMEMUX,
    parameter bit       FWD    = 1'b0,
    localparam int      AW     = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic [NUM_RD*AW-1:0] rd_addr,
    output logic [NUM_RD*DW-1:0] rd_data,
    output logic                 cycle_start
);

    localparam int SW = (NUM_RD > 1) ? $clog2(NUM_RD) : 1;

    if (MODE == RF_TIMEMUX) begin : g_tm
        logic          rd_slot, wr_slot;
        logic [SW-1:0] rd_sel;
        logic [AW-1:0] bank_addr;
        logic [DW-1:0] bank_q;

        rf_slot_seq #(.NUM_RD(NUM_RD)) u_seq (
            .clk         (clk),
            .rst         (rst),
            .rd_slot     (rd_slot),
            .wr_slot     (wr_slot),
            .rd_sel      (rd_sel),
            .cycle_start (cycle_start)
        );

        // one address per slot: the bank never reads and writes together
        assign bank_addr = wr_slot ? wr_addr : rd_addr[rd_sel*AW +: AW];

        rf_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .we    (wr_slot & wr_en),
            .waddr (bank_addr),
            .wdata (wr_data),
            .raddr (bank_addr),
            .rdata (bank_q)
        );

        for (genvar k = 0; k < NUM_RD; k++) begin : g_port
            logic [DW-1:0] stage_r, hold_r;

            always_ff @(posedge clk) begin
                if (rd_slot && rd_sel == SW'(k)) begin
                    stage_r <= bank_q;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_r <= '0;
                end else if (wr_slot) begin
                    hold_r <= stage_r;
                end
            end

            assign rd_data[k*DW +: DW] = hold_r;
        end

        // R7
        rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !wr_slot |=> $stable(rd_data));

        // R5
        start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
            cycle_start |=> !cycle_start);

    end else begin : g_rep
        for (genvar k = 0; k < NUM_RD; k++) begin : g_port
            logic [AW-1:0] ra;
            logic [DW-1:0] bank_q, hold_r;

            assign ra = rd_addr[k*AW +: AW];

            rf_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
                .clk   (clk),
                .we    (wr_en),
                .waddr (wr_addr),
                .wdata (wr_data),
                .raddr (ra),
                .rdata (bank_q)
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_r <= '0;
                end else if (FWD && wr_en && wr_addr == ra) begin
                    hold_r <= wr_data;
                end else begin
                    hold_r <= bank_q;
                end
            end

            assign rd_data[k*DW +: DW] = hold_r;

            if (FWD) begin : g_fwd_chk
                // R4
                fwd_bypass_chk: assert property (@(posedge clk) disable iff (rst)
                    (wr_en && wr_addr == rd_addr[k*AW +: AW])
                    |=> (rd_data[k*DW +: DW] == $past(wr_data)));
            end
        end

        assign cycle_start = 1'b1;
    end

endmodule

// File: tb/regfile_mp_tb_top.sv
`timescale 1ns/100ps
module regfile_mp_tb_top;
    import regfile_mp_pkg::*;

    localparam int DW = 16;
    localparam int DEPTH = 16;
    localparam int NR = 5;
    localparam int AW = 4;
    localparam int SLOTS = NR + 1;
    localparam int LIMIT = 200000;

    typedef struct packed {
        logic [NR*DW-1:0] exp;
        logic [NR-1:0]    msk;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [DW-1:0]  wr_data = '0;
    logic [NR*AW-1:0] rd_addr = '0;
    wire [NR*DW-1:0] rd_tm, rd_rep, rd_fwd;
    wire cs_tm, cs_rep, cs_fwd;

    always #2.5 clk = ~clk;

    regfile_mp #(.MODE(RF_TIMEMUX)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_tm), .cycle_start(cs_tm));
    regfile_mp #(.MODE(RF_REPLICATED), .FWD(1'b0)) dut_rep_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_rep), .cycle_start(cs_rep));
    regfile_mp #(.MODE(RF_REPLICATED), .FWD(1'b1)) dut_fwd_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_fwd), .cycle_start(cs_fwd));

    logic [DW-1:0] ref_mem [DEPTH];
    bit            ref_ok  [DEPTH];
    exp_t  tm_q[$], rep_q[$], fwd_q[$];
    string tm_tag[$], rep_tag[$], fwd_tag[$];
    bit    done = 1'b0;

    int n_chk = 0, n_fail = 0, cyc = 0, sr = 0;
    bit hv = 1'b0;
    logic [NR*DW-1:0] held;

    function automatic logic [NR*AW-1:0] pk(int a0, int a1, int a2, int a3, int a4);
        return {4'(a4), 4'(a3), 4'(a2), 4'(a1), 4'(a0)};
    endfunction

    function automatic exp_t predict(logic we, logic [AW-1:0] wa, logic [DW-1:0] wd,
                                     logic [NR*AW-1:0] ra, bit fwd);
        exp_t e;
        for (int k = 0; k < NR; k++) begin
            logic [AW-1:0] a;
            a = ra[k*AW +: AW];
            if (fwd && we && a == wa) begin
                e.exp[k*DW +: DW] = wd;
                e.msk[k] = 1'b1;
            end else begin
                e.exp[k*DW +: DW] = ref_mem[a];
                e.msk[k] = ref_ok[a];
            end
        end
        return e;
    endfunction

    task automatic commit(logic we, logic [AW-1:0] wa, logic [DW-1:0] wd);
        if (we) begin
            ref_mem[wa] = wd;
            ref_ok[wa] = 1'b1;
        end
    endtask

    task automatic chk_vec(string tag, logic [NR*DW-1:0] act, logic [NR*DW-1:0] exp,
                           logic [NR-1:0] msk);
        for (int k = 0; k < NR; k++) begin
            if (msk[k]) begin
                n_chk++;
                if (act[k*DW +: DW] !== exp[k*DW +: DW]) begin
                    n_fail++;
                    $display("FAIL %s port %0d: actual %h expected %h", tag, k,
                             act[k*DW +: DW], exp[k*DW +: DW]);
                end
            end
        end
    endtask

    task automatic chk_bit(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // monitor: all comparisons and counters live here
    always @(negedge clk) begin
        exp_t  e;
        string t;
        cyc++;
        if (rst) begin
            sr = 0;
            hv = 1'b0;
            if (cyc > 2) begin
                // R8: outputs cleared and sequencer held in slot 0
                chk_vec("R8", rd_tm, '0, '1);
                chk_vec("R8", rd_rep, '0, '1);
                chk_vec("R8", rd_fwd, '0, '1);
                chk_bit("R8", cs_tm, 1'b1);
            end
        end else begin
            sr++;
            // R5: slot 0 once every six clocks
            chk_bit("R5", cs_tm, (sr % SLOTS) == 0);
            if (cs_tm) begin
                held = rd_tm;
                hv = 1'b1;
            end else if (hv) begin
                // R7: outputs constant inside a core cycle
                chk_vec("R7", rd_tm, held, '1);
            end
            if (cs_tm && tm_q.size() > 0) begin
                e = tm_q.pop_front();
                t = tm_tag.pop_front();
                chk_vec(t, rd_tm, e.exp, e.msk);
            end
            if (rep_q.size() > 0) begin
                e = rep_q.pop_front();
                t = rep_tag.pop_front();
                chk_vec(t, rd_rep, e.exp, e.msk);
                chk_bit("R2", cs_rep, 1'b1);
            end
            if (fwd_q.size() > 0) begin
                e = fwd_q.pop_front();
                t = fwd_tag.pop_front();
                chk_vec(t, rd_fwd, e.exp, e.msk);
            end
        end
        if (done || cyc >= LIMIT) begin
            if (!done) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, LIMIT);
            end
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // driver: one core cycle of the time-multiplexed instance
    task automatic tm_cycle(logic we, logic [AW-1:0] wa, logic [DW-1:0] wd,
                            logic [NR*AW-1:0] ra, string tag);
        while (!cs_tm) @(negedge clk);
        #1;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        tm_q.push_back(predict(we, wa, wd, ra, 1'b0));
        tm_tag.push_back(tag);
        commit(we, wa, wd);
        repeat (SLOTS) @(negedge clk);
    endtask

    // driver: one cycle of the replicated instances
    task automatic rep_cycle(logic we, logic [AW-1:0] wa, logic [DW-1:0] wd,
                             logic [NR*AW-1:0] ra, string tag_rep, string tag_fwd);
        #1;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        rep_q.push_back(predict(we, wa, wd, ra, 1'b0));
        rep_tag.push_back(tag_rep);
        fwd_q.push_back(predict(we, wa, wd, ra, 1'b1));
        fwd_tag.push_back(tag_fwd);
        commit(we, wa, wd);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_ok[i] = 1'b0;
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R1: fill every address, reading the previous ones
        for (int i = 0; i < DEPTH; i++) begin
            tm_cycle(1'b1, 4'(i), 16'(i * 16'h0F1D + 16'h3C5A),
                     pk(i - 1, i - 2, i - 3, i - 4, i - 5), "R1");
        end
        tm_cycle(1'b0, 4'd0, 16'h0, pk(15, 0, 7, 8, 1), "R1");
        tm_cycle(1'b0, 4'd0, 16'h0, pk(3, 12, 14, 5, 9), "R1");

        // R9: write strobe low, garbage on data and address
        tm_cycle(1'b0, 4'd3, 16'hDEAD, pk(3, 3, 4, 2, 3), "R9");
        tm_cycle(1'b0, 4'd0, 16'h0, pk(3, 2, 3, 4, 3), "R9");

        // R6: read-before-write on the written address
        tm_cycle(1'b1, 4'd7, 16'hBEEF, pk(7, 7, 7, 7, 7), "R6");
        tm_cycle(1'b0, 4'd0, 16'h0, pk(7, 6, 7, 8, 7), "R6");

        // R8: reset in mid core cycle keeps contents
        while (!cs_tm) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        #1 rst = 1'b1;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        tm_cycle(1'b0, 4'd0, 16'h0, pk(0, 1, 2, 3, 4), "R8");
        tm_cycle(1'b0, 4'd0, 16'h0, pk(15, 7, 11, 13, 10), "R8");

        // replicated instances
        @(negedge clk);
        rep_cycle(1'b0, 4'd0, 16'h0, pk(0, 5, 10, 15, 7), "R2", "R2");
        rep_cycle(1'b1, 4'd9, 16'h5A5A, pk(9, 1, 9, 2, 9), "R3", "R4");
        rep_cycle(1'b0, 4'd9, 16'h1111, pk(9, 9, 9, 9, 9), "R3", "R4");
        for (int i = 0; i < 8; i++) begin
            rep_cycle(1'b1, 4'(i), 16'(i * 16'h2B3 + 16'h0707),
                      pk(i - 1, i, i + 3, i - 2, i), "R2", "R4");
        end
        rep_cycle(1'b0, 4'd4, 16'hFFFF, pk(4, 3, 2, 1, 0), "R9", "R9");
        rep_cycle(1'b0, 4'd0, 16'h0, pk(4, 4, 5, 6, 7), "R9", "R9");

        @(negedge clk);
        #1 done = 1'b1;
    end

endmodule